// File: doc/BRIEF.md
# Dual-Slope Centre-Aligned PWM Timer

This block is an 8-bit timer whose count rises from zero to a turning point and then falls back to zero. Two compare channels, A and B, watch that count and drive centre-aligned PWM outputs. The pulses sit symmetrically about the bottom of each period. A free-running divider supplies the timer tick and works as a clock enable, so everything stays in one clock domain. Each channel has a 2-bit output mode. A per-channel compare value is written into a buffer and takes effect only when the count turns at the top. Three event flags, for bottom, A match and B match, can each raise a shared interrupt request.

The turning point is normally 255. A mode input can make channel A's active compare value the turning point instead. In that case channel A can toggle on every match, which gives a square wave whose frequency is set by the compare value.

At the bottom of the count, a channel may move to its up-match level even though no compare match occurs there. This keeps the waveform symmetric in two cases: when the compare value has just left 255, and when the rising slope never crossed the compare value.

Top module: `pwm_dual_slope`

## Requirements
- R1: `clk_sel_i` picks the tick from a 10-bit divider. The divider is cleared by reset and advances every cycle. Code 1 ticks every cycle. Codes 2, 3, 4 and 5 tick when the divider's low 3, 6, 8 or 10 bits are all ones, which divides by 8, 64, 256 or 1024. Codes 0, 6 and 7 give no tick, and the count then holds.
- R2: On each tick the count moves by one. It turns downward when it reaches the top value and upward when it reaches 0, so with a top of 255 a period lasts 510 ticks. The top value is 255 when `top_a_mode_i`=0 and channel A's active compare value when it is 1. If the count is at or above the top value while rising, it turns down at once. A top value of 0 freezes the count.
- R3: A write (`cmp_wr_i`, with `cmp_sel_i` 0 for A and 1 for B) goes into a buffer. The buffer is copied into the active compare value on the tick in which the count arrives at the top value.
- R4: A match is a tick whose new count equals the active compare value. Its class is the direction held after that tick, so a match at the top counts as downward and a match at 0 counts as upward. In mode 2, an upward match drives the output low and a downward match drives it high. A compare value of 0 therefore keeps the output low, and 255 keeps it high.
- R5: Mode 3 is the inverse of mode 2: an upward match drives the output high and a downward match drives it low.
- R6: Channel A in mode 1 with `top_a_mode_i`=1 inverts its output on every match. Mode 0, channel B in mode 1, and channel A in mode 1 with `top_a_mode_i`=0 all drive the output low.
- R7: In modes 2 and 3, the tick that brings the count to 0 puts the output at its upward-match level if either of two things holds. The first is that the last load at the top replaced 255 with another value. The second is that no upward match happened since the previous bottom while the compare value is below the top value.
- R8: `flags_o` bit 0 is set on every arrival at 0, bit 1 on an A match and bit 2 on a B match. Writing a 1 into `flag_clr_i` clears the matching flag. A set in the same cycle wins over the clear.
- R9: `irq_o` is high whenever some flag is set while its bit in `irq_en_i` (same bit order) is set.
- R10: While reset is asserted, the count is 0 and rising, both outputs are low, and the flags, compare buffers and active compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 3 | Tick divider select |
| top_a_mode_i | input | 1 | Use channel A's compare value as the turning point |
| mode_a_i | input | 2 | Channel A output mode |
| mode_b_i | input | 2 | Channel B output mode |
| cmp_wr_i | input | 1 | Compare buffer write strobe |
| cmp_sel_i | input | 1 | Compare buffer channel select |
| cmp_data_i | input | 8 | Compare buffer write data |
| irq_en_i | input | 3 | Interrupt enable per flag |
| flag_clr_i | input | 3 | Write-one-to-clear for the flags |
| cnt_o | output | 8 | Current count |
| oc_a_o | output | 1 | Channel A waveform |
| oc_b_o | output | 1 | Channel B waveform |
| flags_o | output | 3 | Bottom, A match and B match flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that a nonzero top value is never pushed below the current count in a way that forces the count through zero while it is rising. The stimulus respects both. It drives every input on the falling edge, and it changes the top-select mode only while the count is away from zero. The top-select switch that leaves the count above the new top is exercised on purpose, so that the immediate turn-down and the missed upward match at the next bottom both occur.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned FLG_W  = NUM_CH + 1;
  localparam int unsigned FLG_BOT = 0;
  localparam int unsigned NUM_DIV = 5;
  // low divider bits that must be all ones, per select code 1..5
  localparam int unsigned DIV_SH [NUM_DIV] = '{0, 3, 6, 8, 10};
  localparam int unsigned PRE_W = DIV_SH[NUM_DIV-1];

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_TOGGLE = 2'd1,
    MODE_CLR_UP = 2'd2,
    MODE_SET_UP = 2'd3
  } out_mode_e;
endpackage

// File: rtl/pwm_ds_prescaler.sv
module pwm_ds_prescaler
  import pwm_ds_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  assign cand[0] = 1'b1;
  for (genvar g = 1; g < NUM_DIV; g++) begin : g_div
    assign cand[g] = &pre_q[DIV_SH[g]-1:0];
  end

  always_comb begin
    tick_o = 1'b0;
    if (sel_i != 3'd0 && 32'(sel_i) <= NUM_DIV) tick_o = cand[sel_i - 3'd1];
  end
endmodule

// File: rtl/pwm_ds_updown.sv
module pwm_ds_updown #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             dir_nxt_o,
  output logic             bottom_o,
  output logic             top_hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             dir_q, dir_n, th;
  logic             step;

  assign step = tick_i & (top_i != '0);

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    th    = 1'b0;
    if (step) begin
      if (dir_q) begin
        if (cnt_q >= top_i) begin  // top moved below count: turn now
          cnt_n = cnt_q - 1'b1;
          dir_n = 1'b0;
        end else begin
          cnt_n = cnt_q + 1'b1;
          th    = (cnt_n == top_i);
          dir_n = ~th;
        end
      end else begin
        cnt_n = cnt_q - 1'b1;
        dir_n = (cnt_n == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assign cnt_o     = cnt_q;
  assign step_o    = step;
  assign cnt_nxt_o = cnt_n;
  assign dir_nxt_o = dir_n;
  assign bottom_o  = step & (cnt_n == '0);
  assign top_hit_o = th;

  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) || (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/pwm_ds_chan.sv
module pwm_ds_chan
  import pwm_ds_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter bit          HAS_TOGGLE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic [1:0]       mode_i,
  input  logic             top_a_mode_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             dir_nxt_i,
  input  logic             bottom_i,
  input  logic             top_hit_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] act_o,
  output logic             match_o,
  output logic             oc_o
);
  localparam logic [CNT_W-1:0] MAX_V = '1;

  logic [CNT_W-1:0] buf_q, act_q;
  logic             oc_q, oc_n;
  logic             hit_q, fmax_q;
  logic             match, tgl, pwm, up_lvl, force_up;
  out_mode_e        mode;

  assign mode   = out_mode_e'(mode_i);
  assign tgl    = HAS_TOGGLE && (mode == MODE_TOGGLE) && top_a_mode_i;
  assign pwm    = (mode == MODE_CLR_UP) || (mode == MODE_SET_UP);
  assign up_lvl = (mode == MODE_SET_UP);
  assign match  = step_i & (cnt_nxt_i == act_q);
  // symmetry fix at bottom: left MAX, or rising slope never crossed
  assign force_up = bottom_i & pwm & (fmax_q | (~hit_q & (act_q < top_i)));

  always_comb begin
    oc_n = oc_q;
    if (match) begin
      if (tgl)      oc_n = ~oc_q;
      else if (pwm) oc_n = dir_nxt_i ? up_lvl : ~up_lvl;
    end else if (force_up) begin
      oc_n = up_lvl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      act_q  <= '0;
      oc_q   <= 1'b0;
      hit_q  <= 1'b0;
      fmax_q <= 1'b0;
    end else begin
      oc_q <= oc_n;
      if (wr_i) buf_q <= data_i;
      if (top_hit_i) act_q <= buf_q;
      if (bottom_i)                  hit_q <= match;
      else if (match && dir_nxt_i)   hit_q <= 1'b1;
      if (bottom_i)                  fmax_q <= 1'b0;
      else if (top_hit_i && act_q == MAX_V && buf_q != MAX_V) fmax_q <= 1'b1;
    end
  end

  assign act_o   = act_q;
  assign match_o = match;
  assign oc_o    = (pwm | tgl) ? oc_q : 1'b0;

  AST_ACT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !top_hit_i |=> $stable(act_q)); // R3
  AST_NONINV_UP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && mode == MODE_CLR_UP && dir_nxt_i) |=> !oc_q); // R4
  AST_NONINV_DN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && mode == MODE_CLR_UP && !dir_nxt_i) |=> oc_q); // R4
  AST_INV_UP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && mode == MODE_SET_UP && dir_nxt_i) |=> oc_q); // R5
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
  import pwm_ds_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       clk_sel_i,
  input  logic             top_a_mode_i,
  input  logic [1:0]       mode_a_i,
  input  logic [1:0]       mode_b_i,
  input  logic             cmp_wr_i,
  input  logic             cmp_sel_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic [FLG_W-1:0] irq_en_i,
  input  logic [FLG_W-1:0] flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             oc_a_o,
  output logic             oc_b_o,
  output logic [FLG_W-1:0] flags_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] MAX_V = '1;

  logic             tick, step, dir_nxt, bottom, top_hit;
  logic [CNT_W-1:0] cnt_nxt, top_val;
  logic [CNT_W-1:0] act_v  [NUM_CH];
  logic [1:0]       mode_v [NUM_CH];
  logic [NUM_CH-1:0] match_v, oc_v;
  logic [FLG_W-1:0] flags_q, set_v;

  assign mode_v[0] = mode_a_i;
  assign mode_v[1] = mode_b_i;
  assign top_val   = top_a_mode_i ? act_v[0] : MAX_V;

  pwm_ds_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (clk_sel_i),
    .tick_o (tick)
  );

  pwm_ds_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .top_i     (top_val),
    .cnt_o     (cnt_o),
    .step_o    (step),
    .cnt_nxt_o (cnt_nxt),
    .dir_nxt_o (dir_nxt),
    .bottom_o  (bottom),
    .top_hit_o (top_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_ds_chan #(.CNT_W(CNT_W), .HAS_TOGGLE(g == 0)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (cmp_wr_i && (cmp_sel_i == 1'(g))),
      .data_i       (cmp_data_i),
      .mode_i       (mode_v[g]),
      .top_a_mode_i (top_a_mode_i),
      .step_i       (step),
      .cnt_nxt_i    (cnt_nxt),
      .dir_nxt_i    (dir_nxt),
      .bottom_i     (bottom),
      .top_hit_i    (top_hit),
      .top_i        (top_val),
      .act_o        (act_v[g]),
      .match_o      (match_v[g]),
      .oc_o         (oc_v[g])
    );
    assign set_v[g+1] = match_v[g];
  end
  assign set_v[FLG_BOT] = bottom;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr_i) | set_v;
  end

  assign oc_a_o  = oc_v[0];
  assign oc_b_o  = oc_v[1];
  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & irq_en_i);

  AST_BOTTOM_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bottom |=> flags_q[FLG_BOT]); // R8
  AST_CLR_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i[FLG_BOT] && !bottom) |=> !flags_q[FLG_BOT]); // R8
endmodule

// File: tb/sim_pwm_dual_slope.sv
module sim_pwm_dual_slope;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic       tam = 1'b0;
  logic [1:0] mode_a = 2'd0, mode_b = 2'd0;
  logic       cwr = 1'b0, csel = 1'b0;
  logic [7:0] cdat = 8'd0;
  logic [2:0] ien = 3'd0, fclr = 3'd0;
  logic [7:0] cnt;
  logic       oca, ocb, irq;
  logic [2:0] flg;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_pre, m_cnt, m_dir, m_flg;
  int m_buf [2], m_act [2], m_oc [2], m_hit [2], m_fmax [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dual_slope u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .top_a_mode_i(tam),
    .mode_a_i(mode_a), .mode_b_i(mode_b), .cmp_wr_i(cwr), .cmp_sel_i(csel),
    .cmp_data_i(cdat), .irq_en_i(ien), .flag_clr_i(fclr), .cnt_o(cnt),
    .oc_a_o(oca), .oc_b_o(ocb), .flags_o(flg), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  function automatic int m_out(int ch);
    int md, tg;
    md = ch ? int'(mode_b) : int'(mode_a);
    tg = (ch == 0 && md == 1 && tam) ? 1 : 0;
    return (md >= 2 || tg) ? m_oc[ch] : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_dir = 1; m_flg = 0;
      for (int c = 0; c < 2; c++) begin
        m_buf[c] = 0; m_act[c] = 0; m_oc[c] = 0; m_hit[c] = 0; m_fmax[c] = 0;
      end
    end else begin
      int tick, top, step, n, d, th, bot, setv, md, tg, pwm, up, mt;
      case (clk_sel)
        3'd1: tick = 1;
        3'd2: tick = (m_pre % 8 == 7);
        3'd3: tick = (m_pre % 64 == 63);
        3'd4: tick = (m_pre % 256 == 255);
        3'd5: tick = (m_pre % 1024 == 1023);
        default: tick = 0;
      endcase
      m_pre = (m_pre + 1) % 1024;
      top = tam ? m_act[0] : 255;
      step = tick && top != 0;
      n = m_cnt; d = m_dir; th = 0;
      if (step) begin
        if (m_dir) begin
          if (m_cnt >= top) begin n = m_cnt - 1; d = 0; end
          else begin n = m_cnt + 1; th = (n == top); d = !th; end
        end else begin
          n = m_cnt - 1; d = (n == 0);
        end
      end
      bot = step && n == 0;
      setv = bot;
      for (int c = 0; c < 2; c++) begin
        md = c ? int'(mode_b) : int'(mode_a);
        tg = (c == 0 && md == 1 && tam);
        pwm = (md >= 2);
        up = (md == 3);
        mt = step && n == m_act[c];
        if (mt) begin
          if (tg) m_oc[c] = !m_oc[c];
          else if (pwm) m_oc[c] = d ? up : !up;
        end else if (bot && pwm && (m_fmax[c] || (!m_hit[c] && m_act[c] < top))) begin
          m_oc[c] = up;
        end
        if (bot) m_hit[c] = mt;
        else if (mt && d) m_hit[c] = 1;
        if (bot) m_fmax[c] = 0;
        else if (th && m_act[c] == 255 && m_buf[c] != 255) m_fmax[c] = 1;
        if (th) m_act[c] = m_buf[c];
        if (cwr && int'(csel) == c) m_buf[c] = cdat;
        if (mt) setv = setv | (2 << c);
      end
      m_flg = (m_flg & ~int'(fclr)) | setv;
      m_cnt = n; m_dir = d;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 R2 cnt", cnt, m_cnt);
      chk("R4 R5 R6 R7 oc_a", oca, m_out(0));
      chk("R4 R5 R6 R7 oc_b", ocb, m_out(1));
      chk("R8 flags", flg, m_flg);
      chk("R9 irq", irq, (m_flg & int'(ien)) != 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG && !done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr_cmp(bit ch, int v);
    @(negedge clk); cwr = 1; csel = ch; cdat = 8'(v);
    @(negedge clk); cwr = 0;
  endtask

  task automatic wait_up(int v);
    int prev;
    prev = cnt;
    forever begin
      @(negedge clk);
      if (cnt == v && prev == v - 1) break;
      prev = cnt;
    end
  endtask

  task automatic wait_down(int v);
    int prev;
    prev = cnt;
    forever begin
      @(negedge clk);
      if (cnt == v && prev == v + 1) break;
      prev = cnt;
    end
  endtask

  initial begin
    int t0, t1, hi;
    idle(3);
    chk("R10 cnt", cnt, 0);
    chk("R10 oc_a", oca, 0);
    chk("R10 oc_b", ocb, 0);
    chk("R10 flags", flg, 0);
    rst_n = 1;

    // full-range non-inverted / inverted
    mode_a = 2'd2; mode_b = 2'd3; clk_sel = 3'd1;
    wr_cmp(0, 100); wr_cmp(1, 200);
    idle(600);
    wait_down(1); t0 = cyc;
    wait_down(1); t1 = cyc;
    chk("R2 period 510", t1 - t0, 510);

    // R3: buffer write mid-slope does not act before top
    wait_up(50); wr_cmp(0, 200);
    wait_up(150);
    chk("R3 old compare still active", oca, 0);
    idle(1200);

    // R4 / R5 extremes with compare 0
    wr_cmp(0, 0); wr_cmp(1, 0);
    idle(600);
    hi = 0;
    for (int i = 0; i < 520; i++) begin @(negedge clk); hi += oca; end
    chk("R4 compare 0 stays low", hi, 0);
    hi = 0;
    for (int i = 0; i < 520; i++) begin @(negedge clk); hi += ocb; end
    chk("R5 inverted compare 0 stays high", hi, 520);

    // R7: compare leaves MAX
    wr_cmp(0, 255);
    idle(1100);
    hi = 0;
    for (int i = 0; i < 520; i++) begin @(negedge clk); hi += oca; end
    chk("R4 compare 255 stays high", hi, 520);
    wait_up(10); wr_cmp(0, 60);
    wait_down(1);
    chk("R7 high before bottom", oca, 1);
    @(negedge clk);
    chk("R7 forced low at bottom", oca, 0);
    idle(1100);

    // R6: toggle and disconnected B, turning point from A
    mode_a = 2'd1; mode_b = 2'd1; wr_cmp(0, 50); wr_cmp(1, 20);
    wait_up(100);
    tam = 1;
    hi = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); hi += ocb; end
    chk("R6 channel B mode 1 low", hi, 0);
    mode_b = 2'd2;
    idle(400);
    tam = 0; mode_a = 2'd1;
    idle(20);
    chk("R6 A mode 1 without top select low", oca, 0);
    mode_a = 2'd3;
    wr_cmp(0, 120);
    idle(1100);

    // R7 case 2: rising above a shrunken top skips the up match
    wait_up(150); tam = 1; mode_b = 2'd2; wr_cmp(1, 30);
    idle(700);
    wait_up(40); tam = 0;
    idle(800);

    // R1 divide by 8 and stop
    clk_sel = 3'd2;
    idle(200);
    wait_down(1); t0 = cyc;
    wait_down(1); t1 = cyc;
    chk("R1 divide-8 period", t1 - t0, 4080);
    clk_sel = 3'd0;
    idle(2); t0 = cnt;
    idle(60);
    chk("R1 stopped count holds", cnt, t0);

    // R8 / R9 clears and enables while stopped
    ien = 3'b001;
    @(negedge clk);
    chk("R9 irq from bottom flag", irq, 1);
    fclr = 3'b111; @(negedge clk); fclr = 3'b000;
    chk("R8 flags cleared", flg, 0);
    chk("R9 irq drops", irq, 0);
    clk_sel = 3'd1; ien = 3'b110;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      fclr = (i % 7 == 0) ? 3'b111 : 3'b000;
      if (i % 300 == 0) ien = ien ^ 3'b011;
    end
    fclr = 3'b000;
    clk_sel = 3'd3;
    idle(3000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule